// File: doc/BRIEF.md
# Predicate Lane Permute Unit

This block rearranges the lanes of one or two 32-bit predicate words, in which each bit stands for one byte of a 256-bit vector. A lane of a given width is represented by the single bit at the lowest byte of that lane, so lanes sit at strides of 1, 2, 4 or 8 bits depending on the lane size. The unit offers widening unpack of either half, narrowing pack of two wide-lane masks, even/odd de-interleave, low/high-half interleave, even/odd transpose and full reversal.

A request is offered with `in_vld` together with an operation code, a lane-size code and two source words. The result and an error flag appear one clock later with `out_vld`. Internally each source is gathered into a compact lane vector, the compact vectors are permuted, and the result is spread back out at the output lane stride, so the permute logic never deals with strides. Without a request, the output register keeps its last value.

Top module: `ppu_predicate_permute`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_pred`, `out_err` and `out_vld` are 0.
- R2: A request with `in_vld` high produces its result on `out_pred`/`out_err` with `out_vld` high exactly one clock later; in a cycle after `in_vld` was low, `out_vld` is 0 and `out_pred`/`out_err` keep their values.
- R3: Lane-size code k (0..3 for 8/16/32/64-bit lanes) gives N = 32>>k lanes, lane i at bit i*2^k; source bits off those positions are ignored and result bits off the output-size lane positions are 0.
- R4: Unpack-low (op 0) and unpack-high (op 1) take source lanes at code k and give, at code k+1, result lane i = source lane i (low) or source lane N/2+i (high), for i < N/2.
- R5: Pack-narrow (op 2) reads both sources at code k+1 (N/2 lanes each) and gives, at code k, result lane i = a lane i for i < N/2 and b lane i-N/2 above.
- R6: Pack-even (op 3) gives result lane i = a lane 2i for i < N/2 and b lane 2(i-N/2) above; pack-odd (op 4) uses lanes 2i+1 instead.
- R7: Interleave-low (op 5) gives result lane 2i = a lane i and 2i+1 = b lane i for i < N/2; interleave-high (op 6) uses lanes N/2+i of each source.
- R8: Transpose-even (op 7) gives result 2i = a[2i], 2i+1 = b[2i]; transpose-odd (op 8) gives result 2i = a[2i+1], 2i+1 = b[2i+1].
- R9: Reverse (op 9) gives result lane i = a lane N-1-i.
- R10: Ops 0, 1, 2 with code 3, and any op code 10..15, set `out_err` and return an all-zero result; every legal request clears `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 4 | Operation code (0..9 legal) |
| in_lsize | input | 2 | Lane-size code; narrow side for ops 0..2 |
| in_pred_a | input | 32 | First source predicate |
| in_pred_b | input | 32 | Second source predicate |
| out_vld | output | 1 | Result strobe, one cycle after the request |
| out_pred | output | 32 | Result predicate |
| out_err | output | 1 | Illegal request flag |

## Verification
On every cycle the assertions check the one-cycle timing and hold behaviour, that an error always carries a zero result and is raised for width-changing requests at the 64-bit code, that no result bit lies off the output lane grid, and that reversal preserves the number of active lanes. The exact lane placement of each permutation, its dependence on the lane-size code, and the ignoring of off-grid source bits can only be shown by the bench, which compares every cycle against a behavioural lane model and against hand-computed words for each operation.

// File: rtl/ppu_pkg.sv
package ppu_pkg;

    typedef enum logic [3:0] {
        OP_UNPK_LO   = 4'd0,
        OP_UNPK_HI   = 4'd1,
        OP_PACK_NAR  = 4'd2,
        OP_PACK_EVEN = 4'd3,
        OP_PACK_ODD  = 4'd4,
        OP_ZIP_LO    = 4'd5,
        OP_ZIP_HI    = 4'd6,
        OP_TRN_EVEN  = 4'd7,
        OP_TRN_ODD   = 4'd8,
        OP_REVERSE   = 4'd9
    } ppu_op_e;

    localparam int NUM_SIZES = 4;
    localparam logic [1:0] SZ_WIDEST = 2'd3;

    function automatic logic is_width_change(input logic [3:0] op);
        return (op == OP_UNPK_LO) || (op == OP_UNPK_HI) || (op == OP_PACK_NAR);
    endfunction

endpackage

// File: rtl/ppu_stride_gather.sv
module ppu_stride_gather
    import ppu_pkg::*;
#(
    parameter int PRED_W = 32
) (
    input  logic [PRED_W-1:0] pred,
    input  logic [1:0]        lsize,
    output logic [PRED_W-1:0] lanes
);
    logic [PRED_W-1:0] per_size [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
        for (genvar i = 0; i < PRED_W; i++) begin : g_bit
            if (i < (PRED_W >> k)) begin : g_on
                assign per_size[k][i] = pred[i << k];
            end else begin : g_off
                assign per_size[k][i] = 1'b0;
            end
        end
    end

    assign lanes = per_size[lsize];
endmodule

// File: rtl/ppu_stride_scatter.sv
module ppu_stride_scatter
    import ppu_pkg::*;
#(
    parameter int PRED_W = 32
) (
    input  logic [PRED_W-1:0] lanes,
    input  logic [1:0]        lsize,
    output logic [PRED_W-1:0] pred
);
    logic [PRED_W-1:0] per_size [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
        for (genvar j = 0; j < PRED_W; j++) begin : g_bit
            if ((j % (1 << k)) == 0) begin : g_on
                assign per_size[k][j] = lanes[j >> k];
            end else begin : g_off
                assign per_size[k][j] = 1'b0;
            end
        end
    end

    assign pred = per_size[lsize];
endmodule

// File: rtl/ppu_lane_route.sv
module ppu_lane_route
    import ppu_pkg::*;
#(
    parameter int PRED_W = 32
) (
    input  ppu_op_e           op,
    input  logic [1:0]        lsize,
    input  logic [PRED_W-1:0] a_lanes,
    input  logic [PRED_W-1:0] b_lanes,
    output logic [PRED_W-1:0] r_lanes
);
    localparam int IDXW = $clog2(PRED_W);

    function automatic logic pick(input logic [PRED_W-1:0] v, input int idx);
        logic [IDXW-1:0] sel;
        sel = idx[IDXW-1:0];
        if (idx >= 0 && idx < PRED_W) return v[sel];
        return 1'b0;
    endfunction

    always_comb begin
        int n;
        int half;
        r_lanes = '0;
        n    = PRED_W >> lsize;
        half = n / 2;
        for (int i = 0; i < PRED_W; i++) begin
            if (i < n) begin
                unique case (op)
                    OP_UNPK_LO:   r_lanes[i] = (i < half) ? pick(a_lanes, i) : 1'b0;
                    OP_UNPK_HI:   r_lanes[i] = (i < half) ? pick(a_lanes, half + i) : 1'b0;
                    OP_PACK_NAR:  r_lanes[i] = (i < half) ? pick(a_lanes, i)
                                                          : pick(b_lanes, i - half);
                    OP_PACK_EVEN: r_lanes[i] = (i < half) ? pick(a_lanes, 2 * i)
                                                          : pick(b_lanes, 2 * (i - half));
                    OP_PACK_ODD:  r_lanes[i] = (i < half) ? pick(a_lanes, 2 * i + 1)
                                                          : pick(b_lanes, 2 * (i - half) + 1);
                    OP_ZIP_LO:    r_lanes[i] = ((i % 2) == 1) ? pick(b_lanes, i / 2)
                                                              : pick(a_lanes, i / 2);
                    OP_ZIP_HI:    r_lanes[i] = ((i % 2) == 1) ? pick(b_lanes, half + i / 2)
                                                              : pick(a_lanes, half + i / 2);
                    OP_TRN_EVEN:  r_lanes[i] = ((i % 2) == 1) ? pick(b_lanes, i - 1)
                                                              : pick(a_lanes, i);
                    OP_TRN_ODD:   r_lanes[i] = ((i % 2) == 1) ? pick(b_lanes, i)
                                                              : pick(a_lanes, i + 1);
                    OP_REVERSE:   r_lanes[i] = pick(a_lanes, n - 1 - i);
                    default:      r_lanes[i] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ppu_predicate_permute.sv
module ppu_predicate_permute
    import ppu_pkg::*;
#(
    parameter int PRED_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [3:0]        in_op,
    input  logic [1:0]        in_lsize,
    input  logic [PRED_W-1:0] in_pred_a,
    input  logic [PRED_W-1:0] in_pred_b,
    output logic              out_vld,
    output logic [PRED_W-1:0] out_pred,
    output logic              out_err
);
    ppu_op_e           op;
    logic              legal;
    logic [1:0]        wide_sz;
    logic [1:0]        src_sz;
    logic [1:0]        dst_sz;
    logic [PRED_W-1:0] a_lanes;
    logic [PRED_W-1:0] b_lanes;
    logic [PRED_W-1:0] r_lanes;
    logic [PRED_W-1:0] r_pred;

    assign op      = ppu_op_e'(in_op);
    assign legal   = (in_op <= OP_REVERSE) &&
                     !(is_width_change(in_op) && in_lsize == SZ_WIDEST);
    assign wide_sz = (in_lsize == SZ_WIDEST) ? SZ_WIDEST : in_lsize + 2'd1;
    assign src_sz  = (op == OP_PACK_NAR) ? wide_sz : in_lsize;
    assign dst_sz  = (op == OP_UNPK_LO || op == OP_UNPK_HI) ? wide_sz : in_lsize;

    ppu_stride_gather #(.PRED_W(PRED_W)) u_gather_a (
        .pred  (in_pred_a),
        .lsize (src_sz),
        .lanes (a_lanes)
    );

    ppu_stride_gather #(.PRED_W(PRED_W)) u_gather_b (
        .pred  (in_pred_b),
        .lsize (src_sz),
        .lanes (b_lanes)
    );

    ppu_lane_route #(.PRED_W(PRED_W)) u_route (
        .op      (op),
        .lsize   (in_lsize),
        .a_lanes (a_lanes),
        .b_lanes (b_lanes),
        .r_lanes (r_lanes)
    );

    ppu_stride_scatter #(.PRED_W(PRED_W)) u_scatter (
        .lanes (r_lanes),
        .lsize (dst_sz),
        .pred  (r_pred)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_pred <= '0;
            out_err  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_pred <= legal ? r_pred : '0;
                out_err  <= !legal;
            end
        end
    end
endmodule

// File: rtl/ppu_predicate_permute_chk.sv
module ppu_predicate_permute_chk #(
    parameter int PRED_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [3:0]        in_op,
    input logic [1:0]        in_lsize,
    input logic [PRED_W-1:0] in_pred_a,
    input logic [PRED_W-1:0] in_pred_b,
    input logic              out_vld,
    input logic [PRED_W-1:0] out_pred,
    input logic              out_err
);
    function automatic logic [PRED_W-1:0] grid(input logic [1:0] k);
        logic [PRED_W-1:0] m;
        m = '0;
        for (int j = 0; j < PRED_W; j += (1 << k)) m[j] = 1'b1;
        return m;
    endfunction

    logic [1:0]        osz_q;
    logic [PRED_W-1:0] a_on_grid;

    assign a_on_grid = in_pred_a & grid(in_lsize);

    always_ff @(posedge clk) begin
        if (!rst_n) osz_q <= 2'd0;
        else if (in_vld) osz_q <= (in_op <= 4'd1) ? in_lsize + 2'd1 : in_lsize;
    end

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(out_pred) && $stable(out_err)));

    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_pred == '0));

    // R10
    wide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op <= 4'd2 && in_lsize == 2'd3) |=> out_err);

    // R3
    lane_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_err) |-> ((out_pred & ~grid(osz_q)) == '0));

    // R9
    rev_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_op == 4'd9) |=> ($countones(out_pred) == $countones($past(a_on_grid))));
endmodule

bind ppu_predicate_permute ppu_predicate_permute_chk #(.PRED_W(PRED_W)) u_chk (.*);

// File: tb/ppu_predicate_permute_test.sv
`timescale 1ns/1ps
module ppu_predicate_permute_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [3:0]  in_op;
    logic [1:0]  in_lsize;
    logic [31:0] in_pred_a, in_pred_b;
    logic        out_vld;
    logic [31:0] out_pred;
    logic        out_err;

    always #2 clk = ~clk;

    ppu_predicate_permute uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_lsize(in_lsize),
        .in_pred_a(in_pred_a), .in_pred_b(in_pred_b),
        .out_vld(out_vld), .out_pred(out_pred), .out_err(out_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] exp_pred = '0;
    logic        exp_err  = 1'b0;
    logic        exp_vld  = 1'b0;

    function automatic string req_of(input int op, input int sz, input bit v);
        if (!v) return "R2";
        if (op > 9 || (op <= 2 && sz == 3)) return "R10";
        case (op)
            0, 1:    return "R4";
            2:       return "R5";
            3, 4:    return "R6";
            5, 6:    return "R7";
            7, 8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural lane model: lanes unpacked into integer arrays.
    function automatic void model(input int op, input int sz, input logic [31:0] a,
                                  input logic [31:0] b, output logic [31:0] r, output logic e);
        int la[32], lb[32], lr[32];
        int n, h, isz, osz;
        r = '0; e = 1'b0;
        if (op > 9 || (op <= 2 && sz == 3)) begin e = 1'b1; return; end
        n = 32 >> sz; h = n / 2;
        isz = (op == 2) ? sz + 1 : sz;
        osz = (op <= 1) ? sz + 1 : sz;
        for (int i = 0; i < 32; i++) begin la[i] = 0; lb[i] = 0; lr[i] = 0; end
        for (int i = 0; i < (32 >> isz); i++) begin
            la[i] = a[i << isz]; lb[i] = b[i << isz];
        end
        for (int i = 0; i < h; i++) begin
            case (op)
                0: lr[i] = la[i];
                1: lr[i] = la[h + i];
                2: begin lr[i] = la[i];         lr[h + i] = lb[i];         end
                3: begin lr[i] = la[2 * i];     lr[h + i] = lb[2 * i];     end
                4: begin lr[i] = la[2 * i + 1]; lr[h + i] = lb[2 * i + 1]; end
                5: begin lr[2 * i] = la[i];     lr[2 * i + 1] = lb[i];     end
                6: begin lr[2 * i] = la[h + i]; lr[2 * i + 1] = lb[h + i]; end
                7: begin lr[2 * i] = la[2 * i];     lr[2 * i + 1] = lb[2 * i];     end
                8: begin lr[2 * i] = la[2 * i + 1]; lr[2 * i + 1] = lb[2 * i + 1]; end
                default: begin lr[i] = la[n - 1 - i]; lr[n - 1 - i] = la[i]; end
            endcase
        end
        for (int i = 0; i < (32 >> osz); i++) r[i << osz] = lr[i][0];
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (out_pred !== exp_pred || out_err !== exp_err || out_vld !== exp_vld) begin
            fails++;
            $display("FAIL %s: actual pred=%h err=%b vld=%b expected pred=%h err=%b vld=%b",
                     tag, out_pred, out_err, out_vld, exp_pred, exp_err, exp_vld);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic apply(input bit v, input int op, input int sz,
                         input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic        e;
        in_vld = v; in_op = op[3:0]; in_lsize = sz[1:0]; in_pred_a = a; in_pred_b = b;
        if (v) begin
            model(op, sz, a, b, r, e);
            exp_pred = r; exp_err = e; exp_vld = 1'b1;
        end else begin
            exp_vld = 1'b0;
        end
        @(negedge clk);
        compare(req_of(op, sz, v));
    endtask

    task automatic apply_lit(input int op, input int sz, input logic [31:0] a,
                             input logic [31:0] b, input logic [31:0] lit,
                             input logic lit_err, input string tag);
        apply(1'b1, op, sz, a, b);
        checks++;
        if (out_pred !== lit || out_err !== lit_err) begin
            fails++;
            $display("FAIL %s: actual pred=%h err=%b expected pred=%h err=%b",
                     tag, out_pred, out_err, lit, lit_err);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL R2: actual run still active expected finished (watchdog)");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0001; pats[2] = 32'h8000_0000;
        pats[3] = 32'hA5C3_0F1E; pats[4] = 32'h0123_4567; pats[5] = 32'hFEDC_BA98;
        rst_n = 1'b0; in_vld = 1'b0; in_op = '0; in_lsize = '0; in_pred_a = '0; in_pred_b = '0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        apply(1'b0, 0, 0, '0, '0);
        compare("R1");

        // Hand-computed words
        apply_lit(9, 0, 32'h0000_0001, '0, 32'h8000_0000, 1'b0, "R9");
        apply_lit(0, 0, 32'h0000_000F, '0, 32'h0000_0055, 1'b0, "R4");
        apply_lit(1, 1, 32'h0001_0000, '0, 32'h0000_0001, 1'b0, "R4");
        apply_lit(2, 0, 32'h0000_5555, 32'h0000_0001, 32'h0001_00FF, 1'b0, "R5");
        apply_lit(4, 0, 32'h0000_0002, 32'h8000_0000, 32'h8000_0001, 1'b0, "R6");
        apply_lit(5, 2, 32'h0000_0001, 32'h0000_0010, 32'h0000_1001, 1'b0, "R7");
        apply_lit(8, 3, 32'h0000_0100, 32'h0100_0000, 32'h0100_0001, 1'b0, "R8");
        apply_lit(3, 1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0000_0000, 1'b0, "R3");
        apply_lit(1, 3, 32'h0000_00FF, '0, 32'h0000_0000, 1'b1, "R10");
        apply_lit(12, 0, 32'hFFFF_FFFF, '0, 32'h0000_0000, 1'b1, "R10");
        apply_lit(9, 3, 32'h0000_0001, '0, 32'h0100_0000, 1'b0, "R9");
        repeat (3) apply(1'b0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // Every op at every size over several patterns
        for (int op = 0; op < 16; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int p = 0; p < 6; p++)
                    apply(1'b1, op, sz, pats[p], pats[(p + 3) % 6]);

        // Mixed traffic with idle gaps
        for (int k = 0; k < 4000; k++)
            apply(($urandom % 4) != 0, $urandom % 16, $urandom % 4, $urandom, $urandom);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule